// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This block evaluates a signed comparison on a stream of vector elements, one element per clock, and stores each outcome as one bit of a persistent mask register. The second operand is either the matching element of a second vector or a single scalar captured when the compare begins. The mask outlives the compare. Other vector operations later ask it, per element index, whether a result may be written. A population count returns how many mask bits are set.

A compare is launched with `cmp_start`, which captures the condition, the mode, the active length and the scalar. The same edge clears the whole mask. Each later cycle with `elem_valid` high consumes one element pair and writes the bit at the next index, starting at 0. Because the clear happens first, bits at or above the active length stay 0. Masking is switched on with `mask_enable` and off with `mask_disable`. While masking is off, every element is write-enabled.

Top module: `vcmp_mask_unit`

## Requirements
- R1: The 3-bit condition code selects a signed comparison of operand A against operand B: 0 equal, 1 not equal, 2 A greater than B, 3 A less than B, 4 A greater or equal, 5 A less or equal.
- R2: With `cmp_vs` high at start, operand B is the value of `scalar_in` captured on the start edge. Later changes of `scalar_in` do not affect that compare.
- R3: The k-th accepted element (counted from 0) of a compare sets mask bit k to the comparison result, one cycle after it is accepted. Mask bits do not change while no compare is running.
- R4: A start clears the entire mask, so bits at index `cmp_len` and above read 0. A length of 0 leaves the mask all zero.
- R5: `cmp_busy` rises the cycle after a start with nonzero length. It falls the cycle after the element with index `cmp_len`-1 is accepted. Elements offered while idle are ignored.
- R6: While masking is on, `wr_en` equals mask bit `wr_idx`.
- R7: While masking is off, `wr_en` is 1 for every index. `mask_disable` takes priority over `mask_enable`.
- R8: One cycle after `pop_req`, `pop_valid` is high and `pop_cnt` holds the number of ones the mask held when the request was sampled.
- R9: After reset the mask is zero, masking is off, `cmp_busy` and `pop_valid` are low and `pop_cnt` is 0.
- R10: Condition codes 6 and 7 write 0 into every element they process.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_start | input | 1 | Begin a compare; clears the mask |
| cmp_cond | input | 3 | Condition code |
| cmp_vs | input | 1 | 1: compare against scalar, 0: against vector B |
| cmp_len | input | LEN_W | Active element count, 0..NELEM |
| scalar_in | input | DW | Scalar operand, captured at start |
| elem_valid | input | 1 | An element pair is offered this cycle |
| elem_a | input | DW | Element of operand A (signed) |
| elem_b | input | DW | Element of operand B (signed) |
| mask_enable | input | 1 | Turn masking on |
| mask_disable | input | 1 | Turn masking off |
| wr_idx | input | IDX_W | Element index queried for write enable |
| pop_req | input | 1 | Request a population count |
| mask_o | output | NELEM | Mask register |
| wr_en | output | 1 | Write enable for element `wr_idx` |
| cmp_busy | output | 1 | A compare is consuming elements |
| pop_valid | output | 1 | `pop_cnt` is fresh |
| pop_cnt | output | LEN_W | Number of ones in the mask |

## Verification
The bench builds the unit with 8 mask elements of 4 bits each. This makes every signed operand pair (all 256 of them) reachable under all eight condition codes, including the two unused ones. It also covers every scalar value in scalar mode and every active length from 0 to full. With only 8 indices, the bench can read back the write enable of each element with masking on and off after every length.

// File: rtl/vcmp_mask_unit.sv
module vcmp_mask_unit #(
  parameter int NELEM = 64,
  parameter int DW    = 64,
  localparam int IDX_W = $clog2(NELEM),
  localparam int LEN_W = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_start,
  input  logic [2:0]       cmp_cond,
  input  logic             cmp_vs,
  input  logic [LEN_W-1:0] cmp_len,
  input  logic [DW-1:0]    scalar_in,
  input  logic             elem_valid,
  input  logic [DW-1:0]    elem_a,
  input  logic [DW-1:0]    elem_b,
  input  logic             mask_enable,
  input  logic             mask_disable,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             pop_req,
  output logic [NELEM-1:0] mask_o,
  output logic             wr_en,
  output logic             cmp_busy,
  output logic             pop_valid,
  output logic [LEN_W-1:0] pop_cnt
);

  logic [NELEM-1:0] mask_q;
  logic             mask_on;
  logic             busy_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [2:0]       cond_q;
  logic             vs_q;
  logic [DW-1:0]    scal_q;
  logic [LEN_W-1:0] ones;
  logic             hit;

  wire signed [DW-1:0] opa = elem_a;
  wire signed [DW-1:0] opb = vs_q ? scal_q : elem_b;

  always_comb begin
    case (cond_q)
      3'd0:    hit = (opa == opb);
      3'd1:    hit = (opa != opb);
      3'd2:    hit = (opa >  opb);
      3'd3:    hit = (opa <  opb);
      3'd4:    hit = (opa >= opb);
      3'd5:    hit = (opa <= opb);
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    ones = '0;
    for (int k = 0; k < NELEM; k++) ones = ones + LEN_W'(mask_q[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      busy_q <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
      cond_q <= '0;
      vs_q   <= 1'b0;
      scal_q <= '0;
    end else if (cmp_start) begin
      mask_q <= '0;
      busy_q <= (cmp_len != '0);
      len_q  <= cmp_len;
      idx_q  <= '0;
      cond_q <= cmp_cond;
      vs_q   <= cmp_vs;
      scal_q <= scalar_in;
    end else if (busy_q && elem_valid) begin
      mask_q[idx_q[IDX_W-1:0]] <= hit;
      idx_q <= idx_q + LEN_W'(1);
      if (idx_q == len_q - LEN_W'(1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            mask_on <= 1'b0;
    else if (mask_disable) mask_on <= 1'b0;
    else if (mask_enable)  mask_on <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_valid <= 1'b0;
      pop_cnt   <= '0;
    end else begin
      pop_valid <= pop_req;
      if (pop_req) pop_cnt <= ones;
    end
  end

  assign mask_o   = mask_q;
  assign cmp_busy = busy_q;
  assign wr_en    = !mask_on || mask_q[wr_idx];

endmodule

// File: rtl/vcmp_mask_unit_chk.sv
module vcmp_mask_unit_chk #(
  parameter int NELEM = 64,
  localparam int LEN_W = $clog2(NELEM + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_start,
  input logic             elem_valid,
  input logic [NELEM-1:0] mask_o,
  input logic             cmp_busy,
  input logic             pop_req,
  input logic             pop_valid,
  input logic [LEN_W-1:0] pop_cnt,
  input logic [LEN_W-1:0] len_q,
  input logic             mask_on,
  input logic             wr_en
);

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start |=> (mask_o == '0));

  assert_above_len_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_o >> len_q) == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_busy && !cmp_start) |=> $stable(mask_o));

  assert_busy_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_busy && !elem_valid && !cmp_start) |=> cmp_busy);

  assert_off_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_on |-> wr_en);

  assert_pop_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |=> pop_valid);

  assert_pop_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (pop_cnt == LEN_W'($countones($past(mask_o)))));

endmodule

bind vcmp_mask_unit vcmp_mask_unit_chk #(.NELEM(NELEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_start(cmp_start), .elem_valid(elem_valid),
  .mask_o(mask_o), .cmp_busy(cmp_busy), .pop_req(pop_req),
  .pop_valid(pop_valid), .pop_cnt(pop_cnt), .len_q(len_q),
  .mask_on(mask_on), .wr_en(wr_en)
);

// File: tb/vcmp_mask_unit_bench.sv
module vcmp_mask_unit_bench;
  localparam int N  = 8;
  localparam int DW = 4;
  localparam int LW = 4;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic cmp_start = 0, cmp_vs = 0, elem_valid = 0;
  logic mask_enable = 0, mask_disable = 0, pop_req = 0;
  logic [2:0] cmp_cond = 0;
  logic [LW-1:0] cmp_len = 0;
  logic [DW-1:0] scalar_in = 0, elem_a = 0, elem_b = 0;
  logic [IW-1:0] wr_idx = 0;
  logic [N-1:0] mask_o;
  logic wr_en, cmp_busy, pop_valid;
  logic [LW-1:0] pop_cnt;

  int checks = 0, errors = 0;
  logic [DW-1:0] va [N];
  logic [DW-1:0] vb [N];
  logic [N-1:0] exp_mask;

  vcmp_mask_unit #(.NELEM(N), .DW(DW)) u_vcmp_mask_unit (
    .clk(clk), .rst_n(rst_n), .cmp_start(cmp_start), .cmp_cond(cmp_cond),
    .cmp_vs(cmp_vs), .cmp_len(cmp_len), .scalar_in(scalar_in),
    .elem_valid(elem_valid), .elem_a(elem_a), .elem_b(elem_b),
    .mask_enable(mask_enable), .mask_disable(mask_disable), .wr_idx(wr_idx),
    .pop_req(pop_req), .mask_o(mask_o), .wr_en(wr_en), .cmp_busy(cmp_busy),
    .pop_valid(pop_valid), .pop_cnt(pop_cnt));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit ref_cmp(input int c, input logic [DW-1:0] a, input logic [DW-1:0] b);
    int sa, sb;
    sa = a[DW-1] ? int'(a) - (1 << DW) : int'(a);
    sb = b[DW-1] ? int'(b) - (1 << DW) : int'(b);
    case (c)
      0: return sa == sb;
      1: return sa != sb;
      2: return sa > sb;
      3: return sa < sb;
      4: return sa >= sb;
      5: return sa <= sb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_vec(input int c, input bit vs, input int len, input logic [DW-1:0] s);
    exp_mask = '0;
    for (int i = 0; i < len; i++) exp_mask[i] = ref_cmp(c, va[i], vs ? s : vb[i]);
    @(negedge clk);
    cmp_start = 1; cmp_cond = 3'(c); cmp_vs = vs; cmp_len = LW'(len); scalar_in = s;
    @(negedge clk);
    cmp_start = 0;
    scalar_in = ~s;
    chk("R5 busy after start", {31'd0, cmp_busy}, {31'd0, len != 0});
    chk("R4 mask cleared by start", {24'd0, mask_o}, 32'd0);
    for (int i = 0; i < len; i++) begin
      elem_valid = 1; elem_a = va[i]; elem_b = vb[i];
      @(negedge clk);
    end
    elem_valid = 0;
    chk("R5 idle after last", {31'd0, cmp_busy}, 32'd0);
    chk(c > 5 ? "R10 unused code mask" : (vs ? "R2 scalar mask" : "R1 R3 R4 mask"),
        {24'd0, mask_o}, {24'd0, exp_mask});
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
    chk("R8 pop_valid", {31'd0, pop_valid}, 32'd1);
    chk("R8 pop count", {28'd0, pop_cnt}, $countones(exp_mask));
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset mask", {24'd0, mask_o}, 32'd0);
    chk("R9 reset busy", {31'd0, cmp_busy}, 32'd0);
    chk("R9 reset pop_valid", {31'd0, pop_valid}, 32'd0);
    chk("R9 reset pop_cnt", {28'd0, pop_cnt}, 32'd0);
    chk("R9 reset masking off", {31'd0, wr_en}, 32'd1);

    // R1 R3 R10: every signed pair under every code, vector-vector
    for (int c = 0; c < 8; c++)
      for (int blk = 0; blk < 32; blk++) begin
        for (int i = 0; i < N; i++) begin
          va[i] = DW'((blk * N + i) >> 4);
          vb[i] = DW'(blk * N + i);
        end
        run_vec(c, 1'b0, N, '0);
      end

    // R2: every scalar, every A value, scalar changed after start
    for (int c = 0; c < 6; c++)
      for (int s = 0; s < 16; s++)
        for (int h = 0; h < 2; h++) begin
          for (int i = 0; i < N; i++) begin va[i] = DW'(h * N + i); vb[i] = DW'(s + 3); end
          run_vec(c, 1'b1, N, DW'(s));
        end

    // R4 R6 R7: every length, then query write enables
    for (int len = 0; len <= N; len++) begin
      for (int i = 0; i < N; i++) begin va[i] = DW'(i * 3 + len); vb[i] = DW'(5); end
      run_vec(2, 1'b0, len, '0);
      mask_enable = 1;
      @(negedge clk);
      mask_enable = 0;
      for (int i = 0; i < N; i++) begin
        wr_idx = IW'(i); #1;
        chk("R6 masked write enable", {31'd0, wr_en}, {31'd0, exp_mask[i]});
      end
      mask_disable = 1; mask_enable = 1;
      @(negedge clk);
      mask_disable = 0; mask_enable = 0;
      for (int i = 0; i < N; i++) begin
        wr_idx = IW'(i); #1;
        chk("R7 unmasked write enable", {31'd0, wr_en}, 32'd1);
      end
    end

    // R5: elements while idle are ignored
    elem_valid = 1; elem_a = 4'd1; elem_b = 4'd0;
    repeat (3) @(negedge clk);
    elem_valid = 0;
    chk("R5 idle elements ignored", {24'd0, mask_o}, {24'd0, exp_mask});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule